// File: doc/BRIEF.md
# Branch Target Address Generator

This unit computes the next program counter of a small processor core, one cycle ahead of fetch. The core runs code from two places. One is a local memory of words that covers the low addresses. The other is a shared memory of bytes that covers every address above it. An instruction is one word in the local memory and four bytes in the shared memory. Each cycle the unit takes three things: the address of the current instruction, a flag that says which memory is running, and the fields of a branch immediate. On the next clock edge it presents either the address of the next instruction in sequence or the branch target.

The unit handles two kinds of immediate. A short signed immediate is always relative. In the shared memory it counts whole instructions, so it is multiplied by four. An extension prefix can widen it to a full-width relative offset. A long immediate carries its own relative/absolute selector. Along with the target, the unit raises a registered flag when the taken target lies in the other memory. The fetch stage uses this flag to switch domains. Decode, condition evaluation and the fetch itself stay outside the block.

Top module: `btg_target_gen`

## Requirements
- R1: While reset is asserted and on the first edge after it, `npc_o` is 0 and `cross_o` is 0.
- R2: When `take_i` is 0, `npc_o` on the next edge is `pc_i`+1 if `in_shared_i`=0 and `pc_i`+4 if `in_shared_i`=1. The sum wraps modulo 2^20.
- R3: Short branches (`kind_i`=0, no prefix) running from local memory (`in_shared_i`=0) go to `pc_i`+1 plus the sign-extended 9-bit `short_imm_i`. The offset range is -256 to +255.
- R4: Short branches without a prefix running from shared memory (`in_shared_i`=1) go to `pc_i`+4 plus four times the sign-extended `short_imm_i`.
- R5: A short branch with `ext_valid_i`=1 uses the 20-bit signed offset {`ext_hi_i`, `short_imm_i`}. That offset is added unscaled to the same base as in R2, in either domain, and the branch stays relative.
- R6: A long branch (`kind_i`=1) with `long_rel_i`=0 loads `long_imm_i` into `npc_o` unchanged, in either domain.
- R7: A long branch with `long_rel_i`=1 goes to the base of R2 plus `long_imm_i`. The sum wraps modulo 2^20, and `ext_valid_i` has no effect.
- R8: Addresses below 0x400 belong to local memory and all others to shared memory. `cross_o` is 1 on the edge that presents a taken target only when the target's domain differs from the `in_shared_i` value of that cycle. Otherwise `cross_o` is 0, and it is always 0 for a sequential step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pc_i | input | 20 | Address of the current instruction |
| in_shared_i | input | 1 | 1 when the current instruction runs from shared memory |
| take_i | input | 1 | 1 when the branch is taken this cycle |
| kind_i | input | 1 | Immediate kind: 0 short, 1 long |
| short_imm_i | input | 9 | Signed short immediate |
| ext_valid_i | input | 1 | An extension prefix precedes this short branch |
| ext_hi_i | input | 11 | Upper offset bits supplied by the prefix |
| long_imm_i | input | 20 | Long immediate field |
| long_rel_i | input | 1 | Long immediate selector: 1 relative, 0 absolute |
| npc_o | output | 20 | Registered next program counter |
| cross_o | output | 1 | Registered flag: taken target lies in the other domain |

## Verification
The bench builds the block with its default parameters: a 20-bit counter, a 9-bit short field, a 0x400 domain boundary and a scale shift of two. With these values every one of the 512 short immediates can be applied in both domains from program counters placed next to the domain boundary and at the top of the address space. This exercises the sign extension, the scaling by four, the modulo-2^20 wrap and the domain-crossing flag together. Prefix-widened offsets and long immediates on either side of the boundary are swept as well, so each target computation is compared against arithmetic done in the bench.

// File: rtl/btg_pkg.sv
package btg_pkg;
   typedef enum logic {
      BR_SHORT = 1'b0,
      BR_LONG  = 1'b1
   } br_kind_e;
endpackage

// File: rtl/btg_offset.sv
module btg_offset
   import btg_pkg::*;
#(
   parameter int PC_W     = 20,
   parameter int SHORT_W  = 9,
   parameter int SCALE_SH = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  shared_i,
   input  br_kind_e              kind_i,
   input  logic [SHORT_W-1:0]    short_imm_i,
   input  logic                  ext_valid_i,
   input  logic [PC_W-SHORT_W-1:0] ext_hi_i,
   input  logic [PC_W-1:0]       long_imm_i,
   input  logic                  long_rel_i,
   output logic [PC_W-1:0]       off_o,
   output logic                  abs_o
);
   localparam int HI_W = PC_W - SHORT_W;

   logic [PC_W-1:0] short_sx;
   logic [PC_W-1:0] short_scaled;
   logic [PC_W-1:0] ext_off;

   assign short_sx = {{HI_W{short_imm_i[SHORT_W-1]}}, short_imm_i};
   assign ext_off  = {ext_hi_i, short_imm_i};

   generate
      if (SCALE_SH > 0) begin : g_scale
         assign short_scaled = shared_i ? (short_sx << SCALE_SH) : short_sx;

         // R4: scaled short offsets are whole instructions
         p_scaled_aligned_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (kind_i == BR_SHORT && shared_i && !ext_valid_i) |-> (off_o[SCALE_SH-1:0] == '0));
      end else begin : g_noscale
         assign short_scaled = short_sx;
      end
   endgenerate

   always_comb begin
      abs_o = 1'b0;
      off_o = '0;
      if (kind_i == BR_LONG) begin
         abs_o = ~long_rel_i;
         off_o = long_imm_i;
      end else if (ext_valid_i) begin
         off_o = ext_off;
      end else begin
         off_o = short_scaled;
      end
   end

   // R3: an unscaled short offset stays inside the signed short range
   p_short_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (kind_i == BR_SHORT && !shared_i && !ext_valid_i) |->
      ($countones(off_o[PC_W-1:SHORT_W-1]) == 0 || $countones(off_o[PC_W-1:SHORT_W-1]) == HI_W + 1));

   // R5/R6: short kinds never request an absolute load
   p_short_is_rel_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (kind_i == BR_SHORT) |-> !abs_o);
endmodule

// File: rtl/btg_domain.sv
module btg_domain #(
   parameter int PC_W      = 20,
   parameter int LOCAL_TOP = 1024
) (
   input  logic [PC_W-1:0] addr_i,
   output logic            shared_o
);
   localparam logic [PC_W-1:0] TOP_V = PC_W'(LOCAL_TOP);
   assign shared_o = (addr_i >= TOP_V);
endmodule

// File: rtl/btg_target_gen.sv
module btg_target_gen
   import btg_pkg::*;
#(
   parameter int PC_W      = 20,
   parameter int SHORT_W   = 9,
   parameter int SCALE_SH  = 2,
   parameter int LOCAL_TOP = 1024
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [PC_W-1:0]         pc_i,
   input  logic                    in_shared_i,
   input  logic                    take_i,
   input  logic                    kind_i,
   input  logic [SHORT_W-1:0]      short_imm_i,
   input  logic                    ext_valid_i,
   input  logic [PC_W-SHORT_W-1:0] ext_hi_i,
   input  logic [PC_W-1:0]         long_imm_i,
   input  logic                    long_rel_i,
   output logic [PC_W-1:0]         npc_o,
   output logic                    cross_o
);
   localparam logic [PC_W-1:0] SHARED_STEP = PC_W'(1) << SCALE_SH;
   localparam logic [PC_W-1:0] LOCAL_STEP  = PC_W'(1);

   generate
      if (SHORT_W < 2 || SHORT_W >= PC_W) begin : g_bad_short
         $error("btg_target_gen: SHORT_W must lie between 2 and PC_W-1");
      end
      if (SCALE_SH < 0 || SCALE_SH > 4) begin : g_bad_scale
         $error("btg_target_gen: SCALE_SH out of range");
      end
      if (LOCAL_TOP < 1 || LOCAL_TOP >= (1 << (PC_W - 1))) begin : g_bad_top
         $error("btg_target_gen: LOCAL_TOP out of range");
      end
   endgenerate

   br_kind_e        kind;
   logic [PC_W-1:0] off;
   logic            abs_ld;
   logic [PC_W-1:0] base;
   logic [PC_W-1:0] target;
   logic [PC_W-1:0] next_pc;
   logic            tgt_shared;

   assign kind = br_kind_e'(kind_i);

   btg_offset #(
      .PC_W     (PC_W),
      .SHORT_W  (SHORT_W),
      .SCALE_SH (SCALE_SH)
   ) off_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .shared_i    (in_shared_i),
      .kind_i      (kind),
      .short_imm_i (short_imm_i),
      .ext_valid_i (ext_valid_i),
      .ext_hi_i    (ext_hi_i),
      .long_imm_i  (long_imm_i),
      .long_rel_i  (long_rel_i),
      .off_o       (off),
      .abs_o       (abs_ld)
   );

   assign base    = pc_i + (in_shared_i ? SHARED_STEP : LOCAL_STEP);
   assign target  = abs_ld ? long_imm_i : (base + off);
   assign next_pc = take_i ? target : base;

   btg_domain #(
      .PC_W      (PC_W),
      .LOCAL_TOP (LOCAL_TOP)
   ) dom_i (
      .addr_i   (target),
      .shared_o (tgt_shared)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         npc_o   <= '0;
         cross_o <= 1'b0;
      end else begin
         npc_o   <= next_pc;
         cross_o <= take_i && (tgt_shared != in_shared_i);
      end
   end

   // R2: a sequential step advances by one instruction of the running domain
   p_seq_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !take_i |=> (PC_W'(npc_o - $past(pc_i)) == ($past(in_shared_i) ? SHARED_STEP : LOCAL_STEP)));

   // R6: absolute long branches load the field verbatim
   p_abs_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (take_i && kind_i && !long_rel_i) |=> (npc_o == $past(long_imm_i)));

   // R8: no crossing flag without a taken branch
   p_no_cross_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !take_i |=> !cross_o);

   // R8: the flag agrees with the domain of the presented target
   p_cross_domain_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cross_o |-> ((npc_o >= PC_W'(LOCAL_TOP)) != $past(in_shared_i)));
endmodule

// File: tb/btg_target_gen_tb.sv
module btg_target_gen_tb_top;
   localparam int PC_W = 20;
   localparam int MASK = (1 << PC_W) - 1;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [19:0] pc_i = '0;
   logic        in_shared_i = 1'b0;
   logic        take_i = 1'b0;
   logic        kind_i = 1'b0;
   logic [8:0]  short_imm_i = '0;
   logic        ext_valid_i = 1'b0;
   logic [10:0] ext_hi_i = '0;
   logic [19:0] long_imm_i = '0;
   logic        long_rel_i = 1'b0;
   logic [19:0] npc_o;
   logic        cross_o;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #2 clk = ~clk;

   btg_target_gen dut_i (
      .clk(clk), .rst_n(rst_n), .pc_i(pc_i), .in_shared_i(in_shared_i),
      .take_i(take_i), .kind_i(kind_i), .short_imm_i(short_imm_i),
      .ext_valid_i(ext_valid_i), .ext_hi_i(ext_hi_i), .long_imm_i(long_imm_i),
      .long_rel_i(long_rel_i), .npc_o(npc_o), .cross_o(cross_o)
   );

   task automatic check(input string tag, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   // apply one cycle, then compare both outputs
   task automatic step(input string tag, input int pc, input bit sh, input bit tk,
                       input bit kd, input int imm, input bit ev, input int hi,
                       input int lim, input bit rel);
      int base, off, tgt, exp_pc;
      bit exp_x;
      pc_i = pc[19:0]; in_shared_i = sh; take_i = tk; kind_i = kd;
      short_imm_i = imm[8:0]; ext_valid_i = ev; ext_hi_i = hi[10:0];
      long_imm_i = lim[19:0]; long_rel_i = rel;
      base = (pc + (sh ? 4 : 1)) & MASK;
      if (kd) begin
         tgt = rel ? ((base + lim) & MASK) : (lim & MASK);
      end else if (ev) begin
         off = ((hi & 'h7FF) << 9) | (imm & 'h1FF);
         tgt = (base + off) & MASK;
      end else begin
         off = (imm & 'h100) ? ((imm & 'h1FF) - 512) : (imm & 'h1FF);
         if (sh) off = off * 4;
         tgt = (base + off) & MASK;
      end
      exp_pc = tk ? tgt : base;
      exp_x  = tk && ((tgt >= 'h400) != sh);
      @(posedge clk);
      #1;
      check({tag, " npc"}, int'(npc_o), exp_pc);
      check({tag, " cross"}, int'(cross_o), int'(exp_x));
   endtask

   initial begin
      int pcs[4] = '{'h00010, 'h003F0, 'h00400, 'hFFFF8};
      int his[4] = '{0, 1, 'h400, 'h7FF};
      repeat (3) @(posedge clk);
      #1;
      check("R1 reset npc", int'(npc_o), 0);
      check("R1 reset cross", int'(cross_o), 0);
      rst_n = 1'b1;
      for (int p = 0; p < 4; p++) begin
         for (int s = 0; s < 2; s++) begin
            step("R2 seq", pcs[p], s[0], 1'b0, 1'b0, 'h0FF, 1'b0, 0, 'h12345, 1'b1);
            for (int i = 0; i < 512; i++) begin
               if (s == 0) step("R3 short local", pcs[p], 1'b0, 1'b1, 1'b0, i, 1'b0, 0, 0, 1'b0);
               else        step("R4 short shared", pcs[p], 1'b1, 1'b1, 1'b0, i, 1'b0, 0, 0, 1'b0);
            end
            for (int h = 0; h < 4; h++) begin
               for (int i = 0; i < 512; i += 37) begin
                  step("R5 ext", pcs[p], s[0], 1'b1, 1'b0, i, 1'b1, his[h], 0, 1'b0);
               end
            end
         end
      end
      for (int v = 'h380; v < 'h480; v++) begin
         step("R6 long abs", 'h00800, 1'b1, 1'b1, 1'b1, 'h1AB, 1'b1, 'h7FF, v, 1'b0);
         step("R6 long abs local", 'h00020, 1'b0, 1'b1, 1'b1, 0, 1'b0, 0, v, 1'b0);
      end
      for (int v = 0; v < 64; v++) begin
         step("R7 long rel", 'h003C0, 1'b0, 1'b1, 1'b1, 0, 1'b1, 'h3FF, v * 1039, 1'b1);
         step("R7 long rel wrap", 'hFFFF0, 1'b1, 1'b1, 1'b1, 0, 1'b0, 0, 'hFFF00 + v * 7, 1'b1);
      end
      step("R8 seq no cross", 'h003FF, 1'b0, 1'b0, 1'b0, 0, 1'b0, 0, 0, 1'b0);
      step("R8 cross to shared", 'h003FF, 1'b0, 1'b1, 1'b1, 0, 1'b0, 0, 'h00400, 1'b0);
      step("R8 cross to local", 'h00400, 1'b1, 1'b1, 1'b1, 0, 1'b0, 0, 'h003FF, 1'b0);
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (150000) @(posedge clk);
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule